// File: doc/BRIEF.md
# Interrupt Pending and Selection Unit

This unit keeps two twelve-bit vectors for a small core: one records which interrupt causes are waiting, and the other records which causes software has allowed. Peripherals raise or drop single causes with one-cycle strobes. A single strobe can wipe every waiting cause at once. A register-access path can read either vector and can replace either one as a whole word.

Each cause belongs to one privilege level: user, supervisor or machine. That level's global enable bit from the core's status word gates the cause. The unit raises a take flag when at least one cause is waiting, allowed and globally enabled, all at the same time. It also reports the number of the lowest such cause. The flag and the cause number are combinational, built from the registered vectors and the live status bits. The cause number is meaningful only while the flag is high.

Top module: `irq_pend_arb`

## Requirements
- R1: While reset is held, and on the first cycle after it, the waiting vector, the allowed vector and the take flag are all zero.
- R2: The machine global enable gates causes 3 (software), 7 (timer) and 11 (external). A machine cause is never reported while that enable is low.
- R3: The supervisor global enable gates causes 1 (software), 5 (timer) and 9 (external). A supervisor cause is never reported while that enable is low.
- R4: The user global enable gates causes 0 (software), 4 (timer) and 8 (external). A user cause is never reported while that enable is low.
- R5: The take flag is high exactly when some cause is waiting, allowed and gated on by its level's global enable.
- R6: When several causes qualify, the cause output gives the smallest qualifying index as a 4-bit binary number.
- R7: A post strobe on bit n sets waiting bit n at the next clock edge. A clear strobe on bit n clears it. If both strobes hit the same bit in the same cycle, the bit ends up set.
- R8: The clear-all strobe zeroes the waiting vector at the next edge. A post strobe in the same cycle still sets its bit. Clear-all takes precedence over a whole-word write made in the same cycle.
- R9: A write to the waiting vector replaces it as a whole word. Post and clear strobes in the same cycle are applied on top of the written value.
- R10: A write to the allowed vector replaces it as a whole word at the next edge.
- R11: Bits 2, 6 and 10 of both vectors always read as zero. Writes and strobes aimed at those bits have no effect.
- R12: The take flag and the cause output follow a change of the global enable bits within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_i | input | 12 | Per-cause set strobes |
| clr_i | input | 12 | Per-cause clear strobes |
| clr_all_i | input | 1 | Zero the whole waiting vector |
| ip_we_i | input | 1 | Whole-word write enable, waiting vector |
| ip_wdata_i | input | 12 | Write data, waiting vector |
| ie_we_i | input | 1 | Whole-word write enable, allowed vector |
| ie_wdata_i | input | 12 | Write data, allowed vector |
| gie_m_i | input | 1 | Machine-level global enable |
| gie_s_i | input | 1 | Supervisor-level global enable |
| gie_u_i | input | 1 | User-level global enable |
| ip_o | output | 12 | Current waiting vector |
| ie_o | output | 12 | Current allowed vector |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | 4 | Lowest qualifying cause index |

## Verification
The bench targets the following collisions and what a faulty design would show for each:
- A post and a clear on the same bit: a design that lets the clear win leaves that bit low.
- A whole-word write together with strobes: a design that orders them wrongly loses the strobed bits.
- Clear-all together with a post: a wrong design either keeps stale bits or drops the new one.
- Several causes qualifying at once, across the three levels: a reversed or level-first encoder reports the wrong index.
- A global enable toggled while the vectors are steady: a registered flag would lag by one cycle.
- Writes of all ones: these would reveal any reserved bit that does not stay at zero.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NCAUSE   = 12;
  localparam int unsigned CODE_W   = $clog2(NCAUSE);
  localparam int unsigned KIND_STRIDE = 4;
  localparam int unsigned LVL_U    = 0;
  localparam int unsigned LVL_S    = 1;
  localparam int unsigned LVL_M    = 3;

  typedef logic [NCAUSE-1:0] cvec_t;
  typedef logic [CODE_W-1:0] code_t;

  // Causes sharing one privilege level sit KIND_STRIDE apart.
  function automatic cvec_t level_mask(int unsigned lvl);
    cvec_t m;
    for (int i = 0; i < NCAUSE; i++) m[i] = ((i % KIND_STRIDE) == lvl);
    return m;
  endfunction

  function automatic cvec_t live_mask();
    return level_mask(LVL_U) | level_mask(LVL_S) | level_mask(LVL_M);
  endfunction

  function automatic cvec_t gate_mask(logic m, logic s, logic u);
    return ({NCAUSE{m}} & level_mask(LVL_M))
         | ({NCAUSE{s}} & level_mask(LVL_S))
         | ({NCAUSE{u}} & level_mask(LVL_U));
  endfunction

  // Order: clear-all, else whole-word write, then clears, then posts.
  function automatic cvec_t next_vec(cvec_t cur, logic wipe, logic we,
                                     cvec_t wdata, cvec_t set_s, cvec_t clr_s);
    cvec_t base;
    base = wipe ? '0 : (we ? wdata : cur);
    return ((base & ~clr_s) | set_s) & live_mask();
  endfunction

  function automatic code_t lowest_index(cvec_t v);
    code_t c;
    c = '0;
    for (int i = NCAUSE - 1; i >= 0; i--) if (v[i]) c = code_t'(i);
    return c;
  endfunction
endpackage

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
  import irq_arb_pkg::*;
#(
  parameter bit HAS_STROBES = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  cvec_t wdata,
  input  cvec_t set_s,
  input  cvec_t clr_s,
  input  logic  wipe,
  output cvec_t q
);
  cvec_t nxt;

  generate
    if (HAS_STROBES) begin : g_strobed
      always_comb nxt = next_vec(q, wipe, we, wdata, set_s, clr_s);
    end else begin : g_plain
      always_comb nxt = next_vec(q, 1'b0, we, wdata, '0, '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  cvec_t ip,
  input  cvec_t ie,
  input  logic  gm,
  input  logic  gs,
  input  logic  gu,
  output cvec_t qual
);
  assign qual = ip & ie & gate_mask(gm, gs, gu);
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick
  import irq_arb_pkg::*;
(
  input  cvec_t qual,
  output logic  any,
  output code_t code
);
  assign any  = |qual;
  assign code = lowest_index(qual);
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
  import irq_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] post_i,
  input  logic [11:0] clr_i,
  input  logic        clr_all_i,
  input  logic        ip_we_i,
  input  logic [11:0] ip_wdata_i,
  input  logic        ie_we_i,
  input  logic [11:0] ie_wdata_i,
  input  logic        gie_m_i,
  input  logic        gie_s_i,
  input  logic        gie_u_i,
  output logic [11:0] ip_o,
  output logic [11:0] ie_o,
  output logic        take_o,
  output logic [3:0]  cause_o
);
  cvec_t ip_q, ie_q, qual_w;
  logic  any_w;
  code_t code_w;

  irq_vec_reg #(.HAS_STROBES(1'b1)) u_ip (
    .clk(clk), .rst_n(rst_n), .we(ip_we_i), .wdata(ip_wdata_i),
    .set_s(post_i), .clr_s(clr_i), .wipe(clr_all_i), .q(ip_q)
  );

  irq_vec_reg #(.HAS_STROBES(1'b0)) u_ie (
    .clk(clk), .rst_n(rst_n), .we(ie_we_i), .wdata(ie_wdata_i),
    .set_s('0), .clr_s('0), .wipe(1'b0), .q(ie_q)
  );

  irq_gate u_gate (
    .ip(ip_q), .ie(ie_q), .gm(gie_m_i), .gs(gie_s_i), .gu(gie_u_i),
    .qual(qual_w)
  );

  irq_lowest_pick u_pick (.qual(qual_w), .any(any_w), .code(code_w));

  assign ip_o    = ip_q;
  assign ie_o    = ie_q;
  assign take_o  = any_w;
  assign cause_o = code_w;
endmodule

// File: rtl/irq_pend_arb_chk.sv
module irq_pend_arb_chk
  import irq_arb_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] post_i,
  input logic        clr_all_i,
  input logic        ie_we_i,
  input logic [11:0] ie_wdata_i,
  input logic        gie_m_i,
  input logic        gie_s_i,
  input logic        gie_u_i,
  input logic [11:0] ip_o,
  input logic [11:0] ie_o,
  input logic        take_o,
  input logic [3:0]  cause_o,
  input logic [11:0] qual_w
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (ip_o == '0 && ie_o == '0 && !take_o));

  assert_machine_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !gie_m_i) |-> (cause_o[1:0] != 2'd3));

  assert_super_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !gie_s_i) |-> (cause_o[1:0] != 2'd1));

  assert_user_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !gie_u_i) |-> (cause_o[1:0] != 2'd0));

  assert_take_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (ip_o[cause_o] && ie_o[cause_o]));

  assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((qual_w & ((cvec_t'(1) << cause_o) - cvec_t'(1))) == '0));

  assert_post_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(post_i & live_mask())) |=> ((ip_o & $past(post_i & live_mask())) == $past(post_i & live_mask())));

  assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && post_i == '0) |=> (ip_o == '0));

  assert_ie_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ie_we_i |=> (ie_o == $past(ie_wdata_i & live_mask())));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ip_o | ie_o) & ~live_mask()) == '0);
endmodule

bind irq_pend_arb irq_pend_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .post_i(post_i), .clr_all_i(clr_all_i),
  .ie_we_i(ie_we_i), .ie_wdata_i(ie_wdata_i), .gie_m_i(gie_m_i),
  .gie_s_i(gie_s_i), .gie_u_i(gie_u_i), .ip_o(ip_o), .ie_o(ie_o),
  .take_o(take_o), .cause_o(cause_o), .qual_w(qual_w)
);

// File: tb/irq_pend_arb_bench.sv
`timescale 1ns/1ps
module irq_pend_arb_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] post_i = '0, clr_i = '0, ip_wdata_i = '0, ie_wdata_i = '0;
  logic clr_all_i = 1'b0, ip_we_i = 1'b0, ie_we_i = 1'b0;
  logic gie_m_i = 1'b0, gie_s_i = 1'b0, gie_u_i = 1'b0;
  logic [11:0] ip_o, ie_o;
  logic take_o;
  logic [3:0] cause_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [11:0] m_ip = '0, m_ie = '0;

  always #4 clk = ~clk;

  irq_pend_arb u_irq_pend_arb (.*);

  function automatic bit live(int i);
    return (i % 4) != 2;
  endfunction

  // Level of cause i: 0 user, 1 supervisor, 3 machine.
  function automatic bit lvl_on(int i, logic m, logic s, logic u);
    case (i % 4)
      0: return u;
      1: return s;
      3: return m;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_cause(logic [11:0] ip, logic [11:0] ie, logic m, logic s, logic u);
    for (int i = 0; i < 12; i++)
      if (ip[i] && ie[i] && lvl_on(i, m, s, u)) return i;
    return -1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge: drive, check combinational outputs, advance.
  task automatic step(string tag, logic [11:0] po, logic [11:0] cl, logic ca,
                      logic ipw, logic [11:0] ipd, logic iew, logic [11:0] ied,
                      logic m, logic s, logic u);
    int c;
    logic [11:0] nip, nie;
    post_i = po; clr_i = cl; clr_all_i = ca; ip_we_i = ipw; ip_wdata_i = ipd;
    ie_we_i = iew; ie_wdata_i = ied; gie_m_i = m; gie_s_i = s; gie_u_i = u;
    #1;
    chk({tag, " ip"}, 32'(ip_o), 32'(m_ip));
    chk({tag, " ie"}, 32'(ie_o), 32'(m_ie));
    c = exp_cause(m_ip, m_ie, m, s, u);
    chk({tag, " take"}, 32'(take_o), 32'(c >= 0));
    if (c >= 0) chk({tag, " cause"}, 32'(cause_o), 32'(c));
    for (int i = 0; i < 12; i++) begin
      logic b;
      if (!live(i)) b = 1'b0;
      else begin
        b = ca ? 1'b0 : (ipw ? ipd[i] : m_ip[i]);
        if (cl[i]) b = 1'b0;
        if (po[i]) b = 1'b1;
      end
      nip[i] = b;
      nie[i] = live(i) ? (iew ? ied[i] : m_ie[i]) : 1'b0;
    end
    @(posedge clk);
    m_ip = nip; m_ie = nie;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1: reset with garbage on inputs
    post_i = 12'hFFF; ip_we_i = 1'b1; ip_wdata_i = 12'hFFF; ie_we_i = 1'b1; ie_wdata_i = 12'hFFF;
    gie_m_i = 1; gie_s_i = 1; gie_u_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ip reset", 32'(ip_o), 0);
    chk("R1 ie reset", 32'(ie_o), 0);
    chk("R1 take reset", 32'(take_o), 0);
    post_i = '0; ip_we_i = 0; ie_we_i = 0;
    rst_n = 1'b1;

    // R10 R11: write all ones to the allowed vector
    step("R10 R11", '0, '0, 0, 0, '0, 1, 12'hFFF, 0, 0, 0);
    chk("R11 ie reserved zero", 32'(ie_o), 32'h000_0BBB);
    // R11: post on reserved bits is ignored; R5: machine cause waiting but gate off
    step("R11 R5", 12'h844, '0, 0, 0, '0, 0, '0, 0, 0, 0);
    chk("R11 ip reserved zero", 32'(ip_o), 32'h800);
    chk("R5 gate off no take", 32'(take_o), 0);
    // R2 R12: raising the machine enable takes effect in the same cycle
    gie_m_i = 1; #1;
    chk("R12 take follows enable", 32'(take_o), 1);
    chk("R2 machine external", 32'(cause_o), 11);
    step("R2", '0, '0, 0, 0, '0, 0, '0, 1, 0, 0);
    // R3: supervisor timer
    step("R3", 12'h020, '0, 0, 0, '0, 0, '0, 0, 1, 0);
    gie_s_i = 1; gie_m_i = 0; #1;
    chk("R3 supervisor timer", 32'(cause_o), 5);
    // R6: both machine 11 and supervisor 5 qualify
    gie_m_i = 1; gie_u_i = 1; #1;
    chk("R6 lowest among 5 and 11", 32'(cause_o), 5);
    // R4: user software
    step("R4", 12'h001, '0, 0, 0, '0, 0, '0, 0, 0, 1);
    gie_s_i = 0; gie_m_i = 0; gie_u_i = 1; #1;
    chk("R4 user software", 32'(cause_o), 0);
    // R7: post and clear on the same bit
    step("R7", 12'h080, 12'h080, 0, 0, '0, 0, '0, 1, 1, 1);
    chk("R7 post wins", 32'(ip_o[7]), 1);
    step("R7 clear", '0, 12'h001, 0, 0, '0, 0, '0, 1, 1, 1);
    chk("R7 clear works", 32'(ip_o[0]), 0);
    // R8: clear-all with a write and a post on cause 9
    step("R8", 12'h200, '0, 1, 1, 12'hFFF, 0, '0, 1, 1, 1);
    chk("R8 wipe keeps post", 32'(ip_o), 32'h200);
    // R9: write with concurrent clear and post
    step("R9", 12'h002, 12'h010, 0, 1, 12'h0F1, 0, '0, 1, 1, 1);
    chk("R9 write then strobes", 32'(ip_o), 32'h0A3);
    // R10: clearing allowed vector stops take
    step("R10", '0, '0, 0, 0, '0, 1, 12'h000, 1, 1, 1);
    chk("R10 ie cleared", 32'(take_o), 0);
    step("R10 settle", '0, '0, 0, 0, '0, 0, '0, 1, 1, 1);

    // Random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [11:0] po, cl, ipd, ied;
      logic ca, ipw, iew;
      po  = 12'($urandom & $urandom & $urandom);
      cl  = 12'($urandom & $urandom);
      ipd = 12'($urandom);
      ied = 12'($urandom | $urandom);
      ca  = ($urandom % 23) == 0;
      ipw = ($urandom % 11) == 0;
      iew = ($urandom % 13) == 0;
      step("R5 R6 R7 R8 R9 R10 R11 R12", po, cl, ca, ipw, ipd, iew, ied,
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule